// File: doc/BRIEF.md
# Reset Strap Capture and Boot-Configuration Loader

This block sits between the chip's system reset and the processor core's reset. While the system reset is held low it keeps sampling three strap inputs. The value seen on the last clock edge before reset goes high is kept, and the strap pins are ignored after that, because they carry other signals during normal operation. One strap, the mode strap, chooses between two ways of booting. When it is 0, the other two straps give the boot ROM width, and the core is let out of reset one clock later. When it is 1, the other two straps become the upper device-address bits of a serial EEPROM on an I2C bus. The block then reads a fixed 32-byte configuration image from that EEPROM into an internal byte array.

In EEPROM mode the core reset is released only after a clean load. If the EEPROM does not answer on its address or on the word address, the block raises a sticky error flag and keeps the core in reset until the next system reset. The stored bytes can be read through a combinational read port. This block does not interpret what each configuration bit means.

The system reset is expected to be released synchronously to `clk`, as it is when it comes from an upstream reset synchronizer. SCL and SDA are open-drain: each output only pulls its line low or lets it float.

Top module: `bootcfg_loader`

## Requirements
- R1: The mode and auxiliary straps are captured on the last rising clock edge at which `sys_rst_n` is low. Any strap change after that edge has no effect on the boot width, the device address or the boot path.
- R2: With mode 0, the auxiliary code sets the width outputs as follows: 00 gives `boot_wide`=0 and `width_rsvd`=0 (8-bit); 01 gives `boot_wide`=1 and `width_rsvd`=0 (16-bit); 10 and 11 give `boot_wide`=0 and `width_rsvd`=1 (reserved, treated as 8-bit). With mode 1, both outputs are 0.
- R3: With mode 0 there is no I2C activity: both pull-low outputs stay 0. `core_rst_n` and `cfg_done` go high on the first rising edge after reset release.
- R4: With mode 1, the bus sequence is as follows:
  - a START;
  - the address byte {1010, aux[1], aux[0], 0} with R/W bit 0 (write);
  - the word-address byte 0x00;
  - a repeated START;
  - the same address byte with R/W bit 1 (read).
- R5: The 32 data bytes read in mode 1 are stored in arrival order at indices 0 to 31, most significant bit first on the bus. `rd_data` shows the byte at index `rd_addr` combinationally.
- R6: The master acknowledges data bytes 0 to 30 by pulling SDA low in the ninth clock, and it leaves byte 31 unacknowledged. A STOP follows.
- R7: `core_rst_n` is 0 while `sys_rst_n` is low and for the whole EEPROM load. In mode 1 it rises together with `cfg_done` one clock after the STOP completes. Both then stay high until the next system reset.
- R8: If an address or word-address byte is not acknowledged (SDA high in its ninth clock), the block issues a STOP and sets `cfg_err`. `cfg_err` stays set until the next system reset, `cfg_done` stays 0, and `core_rst_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Active-low system reset, released synchronously |
| strap_mode | input | 1 | Boot-path strap: 1 selects EEPROM load, 0 selects ROM boot |
| strap_aux | input | 2 | Dual-use strap: EEPROM address bits or ROM width code |
| sda_in | input | 1 | Level of the SDA line |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| core_rst_n | output | 1 | Active-low reset to the downstream core |
| boot_wide | output | 1 | 1 when a 16-bit boot ROM is selected |
| width_rsvd | output | 1 | Reserved ROM width code was strapped |
| cfg_done | output | 1 | Boot configuration is complete |
| cfg_err | output | 1 | EEPROM load failed (sticky) |
| rd_addr | input | AW | Configuration byte index |
| rd_data | output | 8 | Configuration byte at `rd_addr` |

## Verification
The assertions check these rules on every cycle:
- the I2C lines stay quiet in ROM mode;
- the width outputs stay stable and consistent once reset is released;
- `cfg_done` and `cfg_err` each stay set once set, and are never set together;
- the core reset stays asserted during system reset and for as long as an error is flagged.

Other behaviour only the bench scenarios can show:
- that the strap value captured is the one from the final reset edge;
- that the bus sequence carries the right address and word address;
- the ACK and NACK pattern across the 32 bytes and the STOP that ends the load;
- that every stored byte matches what an EEPROM model sent;
- that both missing-device and word-address refusal leave the core in reset.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

  // Bus primitive issued to the bit engine
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_BIT   = 2'd2
  } bus_cmd_e;

  typedef enum logic [2:0] {
    SQ_INIT  = 3'd0,
    SQ_START = 3'd1,
    SQ_WBYTE = 3'd2,
    SQ_RBYTE = 3'd3,
    SQ_STOP  = 3'd4,
    SQ_DONE  = 3'd5,
    SQ_FAIL  = 3'd6
  } seq_st_e;

  typedef struct packed {
    logic       eep_en;
    logic [1:0] aux;
  } strap_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Line levels for one quarter phase: {scl_low, sda_low}.
  // Quarter 0 keeps SDA as it was, so SDA never moves on the falling SCL edge.
  function automatic logic [1:0] phase_drive(bus_cmd_e cmd, logic [1:0] ph,
                                             logic wbit, logic sda_hold);
    logic [1:0] r;
    unique case (cmd)
      BC_START: begin
        unique case (ph)
          2'd0:    r = {1'b1, sda_hold};
          2'd1:    r = 2'b10;
          2'd2:    r = 2'b00;
          default: r = 2'b01;
        endcase
      end
      BC_STOP: begin
        unique case (ph)
          2'd0:    r = {1'b1, sda_hold};
          2'd1:    r = 2'b11;
          2'd2:    r = 2'b01;
          default: r = 2'b00;
        endcase
      end
      default: begin
        if (ph == 2'd0) r = {1'b1, sda_hold};
        else            r = {(ph == 2'd1), ~wbit};
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bootcfg_strap_latch.sv
module bootcfg_strap_latch
  import bootcfg_pkg::*;
(
  input  logic       clk,
  input  logic       sys_rst_n,
  input  logic       strap_mode,
  input  logic [1:0] strap_aux,
  output strap_t     straps_q,
  output logic       boot_wide,
  output logic       width_rsvd,
  output logic [6:0] dev_addr
);

  strap_t cap_q;

  // Sampling register: loads on every edge while reset is low and holds afterwards
  always_ff @(posedge clk) begin
    if (!sys_rst_n) begin
      cap_q <= '{eep_en: strap_mode, aux: strap_aux};
    end
  end

  assign straps_q   = cap_q;
  assign boot_wide  = !cap_q.eep_en && (cap_q.aux == 2'b01);
  assign width_rsvd = !cap_q.eep_en && cap_q.aux[1];
  assign dev_addr   = {DEV_TYPE, cap_q.aux, 1'b0};

endmodule

// File: rtl/bootcfg_i2c_phy.sv
module bootcfg_i2c_phy
  import bootcfg_pkg::*;
#(
  parameter int CLK_QDIV = 125
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  bus_cmd_e cmd,
  input  logic     wbit,
  input  logic     sda_in,
  output logic     fin,
  output logic     rbit,
  output logic     scl_low,
  output logic     sda_low
);

  localparam int CW = (CLK_QDIV > 1) ? $clog2(CLK_QDIV) : 1;
  localparam logic [CW-1:0] QLAST = CW'(CLK_QDIV - 1);

  logic          busy_q, busy_d;
  bus_cmd_e      cmd_q, cmd_d;
  logic          wbit_q, wbit_d;
  logic [1:0]    ph_q, ph_d;
  logic [CW-1:0] qcnt_q, qcnt_d;
  logic          scl_q, scl_d;
  logic          sda_q, sda_d;
  logic          rbit_q, rbit_d;
  logic          fin_q, fin_d;
  logic          qend;

  assign qend = (qcnt_q == QLAST);

  always_comb begin
    busy_d = busy_q;
    cmd_d  = cmd_q;
    wbit_d = wbit_q;
    ph_d   = ph_q;
    qcnt_d = qcnt_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    rbit_d = rbit_q;
    fin_d  = 1'b0;
    if (!busy_q) begin
      if (go) begin
        busy_d         = 1'b1;
        cmd_d          = cmd;
        wbit_d         = wbit;
        ph_d           = 2'd0;
        qcnt_d         = '0;
        {scl_d, sda_d} = phase_drive(cmd, 2'd0, wbit, sda_q);
      end
    end else if (!qend) begin
      qcnt_d = qcnt_q + 1'b1;
    end else begin
      qcnt_d = '0;
      if (ph_q == 2'd2) rbit_d = sda_in;
      if (ph_q == 2'd3) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end else begin
        ph_d           = ph_q + 2'd1;
        {scl_d, sda_d} = phase_drive(cmd_q, ph_q + 2'd1, wbit_q, sda_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= BC_STOP;
      wbit_q <= 1'b1;
      ph_q   <= 2'd0;
      qcnt_q <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      rbit_q <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cmd_q  <= cmd_d;
      wbit_q <= wbit_d;
      ph_q   <= ph_d;
      qcnt_q <= qcnt_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      rbit_q <= rbit_d;
      fin_q  <= fin_d;
    end
  end

  assign fin     = fin_q;
  assign rbit    = rbit_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;

endmodule

// File: rtl/bootcfg_seq.sv
module bootcfg_seq
  import bootcfg_pkg::*;
#(
  parameter  int NBYTES = 32,
  localparam int AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eep_en,
  input  logic [6:0]    dev_addr,
  input  logic          fin,
  input  logic          rbit,
  output logic          go,
  output bus_cmd_e      cmd,
  output logic          wbit,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          err
);

  localparam logic [AW-1:0] LAST = AW'(NBYTES - 1);

  seq_st_e       st_q, st_d;
  logic          wait_q, wait_d;
  logic [3:0]    bidx_q, bidx_d;
  logic [1:0]    step_q, step_d;
  logic [AW-1:0] rcnt_q, rcnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          failp_q, failp_d;
  logic [7:0]    txbyte;
  logic          ninth;

  assign ninth = bidx_q[3];

  always_comb begin
    unique case (step_q)
      2'd0:    txbyte = {dev_addr, 1'b0};
      2'd1:    txbyte = 8'h00;
      default: txbyte = {dev_addr, 1'b1};
    endcase
  end

  // Command presented to the bit engine
  always_comb begin
    go   = !wait_q && (st_q == SQ_START || st_q == SQ_WBYTE ||
                       st_q == SQ_RBYTE || st_q == SQ_STOP);
    cmd  = BC_BIT;
    wbit = 1'b1;
    unique case (st_q)
      SQ_START: cmd = BC_START;
      SQ_STOP:  cmd = BC_STOP;
      SQ_WBYTE: wbit = ninth ? 1'b1 : txbyte[3'd7 - bidx_q[2:0]];
      SQ_RBYTE: wbit = ninth ? (rcnt_q == LAST) : 1'b1;
      default:  ;
    endcase
  end

  assign wr_addr = rcnt_q;
  assign wr_data = {sh_q[6:0], rbit};

  always_comb begin
    st_d    = st_q;
    wait_d  = wait_q;
    bidx_d  = bidx_q;
    step_d  = step_q;
    rcnt_d  = rcnt_q;
    sh_d    = sh_q;
    failp_d = failp_q;
    wr_en   = 1'b0;
    if (go) wait_d = 1'b1;
    unique case (st_q)
      SQ_INIT: st_d = eep_en ? SQ_START : SQ_DONE;
      SQ_START: begin
        if (fin) begin
          wait_d = 1'b0;
          bidx_d = 4'd0;
          st_d   = SQ_WBYTE;
        end
      end
      SQ_WBYTE: begin
        if (fin) begin
          wait_d = 1'b0;
          if (!ninth) begin
            bidx_d = bidx_q + 4'd1;
          end else begin
            bidx_d = 4'd0;
            if (rbit) begin
              failp_d = 1'b1;
              st_d    = SQ_STOP;
            end else begin
              unique case (step_q)
                2'd0: step_d = 2'd1;
                2'd1: begin
                  step_d = 2'd2;
                  st_d   = SQ_START;
                end
                default: begin
                  rcnt_d = '0;
                  st_d   = SQ_RBYTE;
                end
              endcase
            end
          end
        end
      end
      SQ_RBYTE: begin
        if (fin) begin
          wait_d = 1'b0;
          if (!ninth) begin
            sh_d   = {sh_q[6:0], rbit};
            bidx_d = bidx_q + 4'd1;
            if (bidx_q[2:0] == 3'd7) wr_en = 1'b1;
          end else begin
            bidx_d = 4'd0;
            if (rcnt_q == LAST) st_d = SQ_STOP;
            else                rcnt_d = rcnt_q + 1'b1;
          end
        end
      end
      SQ_STOP: begin
        if (fin) begin
          wait_d = 1'b0;
          st_d   = failp_q ? SQ_FAIL : SQ_DONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_INIT;
      wait_q  <= 1'b0;
      bidx_q  <= 4'd0;
      step_q  <= 2'd0;
      rcnt_q  <= '0;
      sh_q    <= 8'h00;
      failp_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      bidx_q  <= bidx_d;
      step_q  <= step_d;
      rcnt_q  <= rcnt_d;
      sh_q    <= sh_d;
      failp_q <= failp_d;
    end
  end

  assign done = (st_q == SQ_DONE);
  assign err  = (st_q == SQ_FAIL);

endmodule

// File: rtl/bootcfg_store.sv
module bootcfg_store #(
  parameter  int NBYTES = 32,
  localparam int AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
  import bootcfg_pkg::*;
#(
  parameter  int CLK_QDIV = 125,
  parameter  int NBYTES   = 32,
  localparam int AW       = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          sys_rst_n,
  input  logic          strap_mode,
  input  logic [1:0]    strap_aux,
  input  logic          sda_in,
  output logic          scl_pull_low,
  output logic          sda_pull_low,
  output logic          core_rst_n,
  output logic          boot_wide,
  output logic          width_rsvd,
  output logic          cfg_done,
  output logic          cfg_err,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  strap_t        straps_q;
  logic          eep_en;
  logic [6:0]    dev_addr;
  logic          go, wbit, fin, rbit;
  bus_cmd_e      cmd;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          seq_done, seq_err;
  logic          bw, rsv;

  bootcfg_strap_latch u_straps (
    .clk        (clk),
    .sys_rst_n  (sys_rst_n),
    .strap_mode (strap_mode),
    .strap_aux  (strap_aux),
    .straps_q   (straps_q),
    .boot_wide  (bw),
    .width_rsvd (rsv),
    .dev_addr   (dev_addr)
  );

  assign eep_en = straps_q.eep_en;

  bootcfg_seq #(.NBYTES(NBYTES)) u_seq (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .eep_en   (eep_en),
    .dev_addr (dev_addr),
    .fin      (fin),
    .rbit     (rbit),
    .go       (go),
    .cmd      (cmd),
    .wbit     (wbit),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (seq_done),
    .err      (seq_err)
  );

  bootcfg_i2c_phy #(.CLK_QDIV(CLK_QDIV)) u_phy (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .go      (go),
    .cmd     (cmd),
    .wbit    (wbit),
    .sda_in  (sda_in),
    .fin     (fin),
    .rbit    (rbit),
    .scl_low (scl_pull_low),
    .sda_low (sda_pull_low)
  );

  bootcfg_store #(.NBYTES(NBYTES)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign core_rst_n = seq_done;
  assign cfg_done   = seq_done;
  assign cfg_err    = seq_err;
  assign boot_wide  = bw;
  assign width_rsvd = rsv;

endmodule

// File: rtl/bootcfg_loader_chk.sv
module bootcfg_loader_chk (
  input logic clk,
  input logic sys_rst_n,
  input logic eep_en,
  input logic scl_pull_low,
  input logic sda_pull_low,
  input logic core_rst_n,
  input logic boot_wide,
  input logic width_rsvd,
  input logic cfg_done,
  input logic cfg_err
);

  logic live_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) live_q <= 1'b0;
    else            live_q <= 1'b1;
  end

  a_r7_core_held_in_reset: assert property (@(posedge clk)
    !sys_rst_n |-> !core_rst_n);

  a_r3_rom_bus_idle: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !eep_en |-> (!scl_pull_low && !sda_pull_low));

  a_r1_width_stable: assert property (@(posedge clk) disable iff (!sys_rst_n)
    live_q |=> ($stable(boot_wide) && $stable(width_rsvd)));

  a_r2_rsvd_is_narrow: assert property (@(posedge clk) disable iff (!sys_rst_n)
    width_rsvd |-> !boot_wide);

  a_r2_eep_no_width: assert property (@(posedge clk) disable iff (!sys_rst_n)
    eep_en |-> (!boot_wide && !width_rsvd));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cfg_err |=> cfg_err);

  a_r8_err_holds_core: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cfg_err |-> (!core_rst_n && !cfg_done));

  a_r7_release_sticky: assert property (@(posedge clk) disable iff (!sys_rst_n)
    core_rst_n |=> (core_rst_n && cfg_done));

endmodule

bind bootcfg_loader bootcfg_loader_chk u_chk (
  .clk          (clk),
  .sys_rst_n    (sys_rst_n),
  .eep_en       (eep_en),
  .scl_pull_low (scl_pull_low),
  .sda_pull_low (sda_pull_low),
  .core_rst_n   (core_rst_n),
  .boot_wide    (boot_wide),
  .width_rsvd   (width_rsvd),
  .cfg_done     (cfg_done),
  .cfg_err      (cfg_err)
);

// File: tb/bootcfg_loader_bench.sv
`timescale 1ns/1ps
module bootcfg_loader_bench;

  localparam int QDIV = 2;
  localparam int NB   = 32;
  localparam int AW   = 5;

  localparam int PH_IDLE = 0;
  localparam int PH_ADDR = 1;
  localparam int PH_WORD = 2;
  localparam int PH_TX   = 3;

  logic          clk = 1'b0;
  logic          sys_rst_n;
  logic          strap_mode;
  logic [1:0]    strap_aux;
  logic          scl_pull_low, sda_pull_low;
  logic          core_rst_n, boot_wide, width_rsvd, cfg_done, cfg_err;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          sda_bus, scl_bus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // EEPROM model state
  logic       s_drv = 1'b0;
  logic       scl_p = 1'b1;
  logic       sda_p = 1'b1;
  logic [1:0] slv_aux = 2'b00;
  bit         nack_word = 0;
  int         s_ph = PH_IDLE;
  int         nxt_ph = PH_IDLE;
  int         bcnt = 0;
  bit         fresh = 0;
  logic [7:0] rx = 8'h00;
  logic [7:0] txb;
  int         ptr = 0;
  bit         m_ack = 0;
  int         acks = 0, nacks = 0, stops = 0;
  int         word_rx = -1;
  int         addr_w_seen = 0, addr_r_seen = 0;

  always #4 clk = ~clk;

  assign scl_bus = !scl_pull_low;
  assign sda_bus = !(sda_pull_low || s_drv);

  bootcfg_loader #(.CLK_QDIV(QDIV), .NBYTES(NB)) u_bootcfg_loader (
    .clk          (clk),
    .sys_rst_n    (sys_rst_n),
    .strap_mode   (strap_mode),
    .strap_aux    (strap_aux),
    .sda_in       (sda_bus),
    .scl_pull_low (scl_pull_low),
    .sda_pull_low (sda_pull_low),
    .core_rst_n   (core_rst_n),
    .boot_wide    (boot_wide),
    .width_rsvd   (width_rsvd),
    .cfg_done     (cfg_done),
    .cfg_err      (cfg_err),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data)
  );

  function automatic logic [7:0] pat(int p, logic [1:0] a);
    return 8'((p * 29) + 7 + (int'(a) * 64));
  endfunction

  // Behavioural EEPROM, evaluated away from the active edge
  always @(negedge clk) begin
    if (scl_p && scl_bus && sda_p && !sda_bus) begin
      s_ph = PH_ADDR; bcnt = 0; fresh = 1; s_drv = 1'b0; rx = 8'h00;
    end else if (scl_p && scl_bus && !sda_p && sda_bus) begin
      s_ph = PH_IDLE; s_drv = 1'b0; stops++;
    end else if (!scl_p && scl_bus) begin
      if (bcnt < 8 && (s_ph == PH_ADDR || s_ph == PH_WORD)) rx = {rx[6:0], sda_bus};
      if (bcnt == 8 && s_ph == PH_TX) m_ack = !sda_bus;
    end else if (scl_p && !scl_bus) begin
      if (fresh) begin
        fresh = 0;
      end else if (bcnt == 8) begin
        bcnt = 0; s_drv = 1'b0;
        if (s_ph == PH_TX) begin
          if (m_ack) begin
            acks++; ptr++; txb = pat(ptr, slv_aux); s_drv = !txb[7];
          end else begin
            nacks++; s_ph = PH_IDLE;
          end
        end else begin
          s_ph = nxt_ph;
          if (s_ph == PH_TX) begin txb = pat(ptr, slv_aux); s_drv = !txb[7]; end
        end
      end else begin
        bcnt++;
        if (bcnt == 8) begin
          if (s_ph == PH_ADDR) begin
            if (rx[7:1] == {4'b1010, slv_aux, 1'b0}) begin
              s_drv = 1'b1;
              nxt_ph = rx[0] ? PH_TX : PH_WORD;
              if (rx[0]) addr_r_seen++; else addr_w_seen++;
            end else begin
              s_drv = 1'b0; nxt_ph = PH_IDLE;
            end
          end else if (s_ph == PH_WORD) begin
            word_rx = int'(rx); ptr = int'(rx);
            s_drv = !nack_word; nxt_ph = PH_IDLE;
          end else if (s_ph == PH_TX) begin
            s_drv = 1'b0;
          end
        end else if (s_ph == PH_TX) begin
          txb = pat(ptr, slv_aux); s_drv = !txb[3'(7 - bcnt)];
        end
      end
    end
    scl_p = scl_bus;
    sda_p = sda_bus;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic slave_clear(input logic [1:0] a, input bit nw);
    slv_aux = a; nack_word = nw; s_ph = PH_IDLE; s_drv = 1'b0;
    acks = 0; nacks = 0; stops = 0; word_rx = -1; addr_w_seen = 0; addr_r_seen = 0;
  endtask

  // Early strap values are replaced one edge before release; the late ones must win
  task automatic apply_reset(input logic m_early, input logic [1:0] a_early,
                             input logic m_fin, input logic [1:0] a_fin);
    sys_rst_n = 1'b0; strap_mode = m_early; strap_aux = a_early;
    repeat (6) @(negedge clk);
    check("R7", "core_rst_n in reset", int'(core_rst_n), 0);
    check("R7", "done in reset", int'(cfg_done), 0);
    check("R8", "err in reset", int'(cfg_err), 0);
    check("R3", "bus released in reset", int'(scl_pull_low | sda_pull_low), 0);
    strap_mode = m_fin; strap_aux = a_fin;
    @(negedge clk);
    sys_rst_n = 1'b1;
  endtask

  task automatic rom_case(input logic [1:0] a);
    int busy_seen = 0;
    apply_reset(1'b1, ~a, 1'b0, a);
    #1;
    check("R3", "core held before first edge", int'(core_rst_n), 0);
    @(negedge clk);
    check("R3", "core released one clock later", int'(core_rst_n), 1);
    check("R3", "done one clock later", int'(cfg_done), 1);
    check("R2", "boot_wide", int'(boot_wide), int'(a == 2'b01));
    check("R2", "width_rsvd", int'(width_rsvd), int'(a[1]));
    strap_mode = 1'b1; strap_aux = ~a;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_pull_low || sda_pull_low) busy_seen++;
    end
    check("R3", "no bus activity in ROM mode", busy_seen, 0);
    check("R1", "boot_wide after strap change", int'(boot_wide), int'(a == 2'b01));
    check("R1", "width_rsvd after strap change", int'(width_rsvd), int'(a[1]));
  endtask

  task automatic eep_case(input logic [1:0] a);
    int early = 0;
    int stops_at_done = -1;
    int cyc = 0;
    slave_clear(a, 0);
    apply_reset(1'b0, ~a, 1'b1, a);
    strap_mode = 1'b0; strap_aux = ~a;
    while (!cfg_done && !cfg_err && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (core_rst_n && !cfg_done) early++;
      if (cfg_done && stops_at_done < 0) stops_at_done = stops;
    end
    check("R4", "load finished", int'(cfg_done), 1);
    check("R8", "no error on good load", int'(cfg_err), 0);
    check("R7", "core released after load", int'(core_rst_n), 1);
    check("R7", "no early core release", early, 0);
    check("R7", "STOP seen before done", stops_at_done, 1);
    check("R4", "write address acked once", addr_w_seen, 1);
    check("R4", "read address acked once", addr_r_seen, 1);
    check("R4", "word address", word_rx, 0);
    check("R6", "bytes acked by master", acks, NB - 1);
    check("R6", "final byte not acked", nacks, 1);
    check("R2", "width outputs in EEPROM mode", int'({boot_wide, width_rsvd}), 0);
    for (int k = 0; k < NB; k++) begin
      rd_addr = AW'(k);
      #1;
      check("R5", $sformatf("byte %0d", k), int'(rd_data), int'(pat(k, a)));
    end
    repeat (20) @(negedge clk);
    check("R7", "core stays released", int'(core_rst_n), 1);
  endtask

  task automatic fail_case(input logic [1:0] a, input bit word_refuse);
    int cyc = 0;
    slave_clear(word_refuse ? a : (a ^ 2'b01), word_refuse);
    apply_reset(1'b1, a, 1'b1, a);
    while (!cfg_err && !cfg_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check("R8", "error flagged", int'(cfg_err), 1);
    check("R8", "done stays low", int'(cfg_done), 0);
    check("R8", "STOP issued on failure", stops, 1);
    repeat (400) @(negedge clk);
    check("R8", "error sticky", int'(cfg_err), 1);
    check("R8", "core held after failure", int'(core_rst_n), 0);
    check("R8", "bus released after failure", int'(scl_pull_low | sda_pull_low), 0);
  endtask

  initial begin
    sys_rst_n = 1'b0; strap_mode = 1'b0; strap_aux = 2'b00; rd_addr = '0;
    for (int a = 0; a < 4; a++) rom_case(2'(a));
    for (int a = 0; a < 4; a++) eep_case(2'(a));
    fail_case(2'b10, 0);
    fail_case(2'b01, 1);
    rom_case(2'b01);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule